// File: doc/BRIEF.md
# Clock Controller Register Bank

This block is the software-visible register file of a chip's clock controller. It holds the control words for thirteen PLLs, the bus clock divider settings, the peripheral clock words and the DRAM clock configuration. Software reaches it over a simple word-wide bus: a read strobe or a write strobe, a byte offset, and 32-bit data. No oscillators, dividers or gates sit behind it. The block only stores words and applies a few write side effects, so that boot firmware which polls for PLL lock, or waits for an update strobe to clear, moves on at once.

Writing a PLL control word with its enable bit set stores that word with its lock bit forced high in the same write. Two DRAM update strobe bits are dropped on every write and never read back as set. Accesses past the last implemented word return zero and raise an error pulse. Writes to words that have no special handling are stored unchanged and raise an "unimplemented" pulse.

A small response state machine records what the previous cycle's access was. Its outputs come straight from that state. The states are IDLE (no access), READ_OK (in-range read), READ_OOB (out-of-range read), WRITE_STORED (write to a word with side effects), WRITE_PLAIN (write to a word with no special handling) and WRITE_OOB (out-of-range write). On every clock edge the strobes pick the next state, whatever the current state is. A write strobe moves the machine to WRITE_OOB, WRITE_PLAIN or WRITE_STORED, according to the offset. A read strobe alone moves it to READ_OOB or READ_OK. No strobe returns it to IDLE.

Top module: `clkctl_regbank`

## Requirements
- R1: Each access moves one 32-bit word. Address bits [11:2] pick the word and bits [1:0] are ignored. After a cycle with `rd_en` high and `wr_en` low, `rdata` holds the addressed word and `rvalid` is high in the next cycle. In every other cycle `rdata` is zero and `rvalid` is low.
- R2: The PLL words are at byte offsets 0x000, 0x008, 0x010, 0x018, 0x020, 0x028, 0x02C, 0x030, 0x034, 0x038, 0x040 and 0x048. When such a word is written with bit 31 (enable) set, it is stored with bit 28 (lock) set and all other bits as written.
- R3: When a PLL word is written with bit 31 clear, the whole value is stored exactly as written, including bit 28.
- R4: The word at 0x04C is a PLL word in the sense of R2 and R3. In addition, its bit 30 is always stored as 0.
- R5: The word at 0x0F4 always stores bit 16 as 0. Its other bits are stored as written.
- R6: Offsets from 0x324 upward are out of range. A read there returns zero with `rvalid` high, and a write there changes no stored word. Either kind of access raises `err` in the next cycle.
- R7: A write to an in-range offset not listed in R2, R4 or R5 stores the value unchanged and raises `unimpl` in the next cycle. Writes to the offsets listed in R2, R4 and R5 do not raise `unimpl`.
- R8: After reset, every word reads zero except these: 0x00001000 at 0x000 and 0x020; 0x00035514 at 0x008; 0x03006207 at 0x010, 0x018, 0x030, 0x038 and 0x048; 0x00041811 at 0x028 and 0x02C; 0x00001811 at 0x034; 0x00000515 at 0x040; 0x00001800 at 0x04C; 0x00001010 at 0x054; 0x01000000 at 0x058; 0x00000001 at 0x0F0; 0x0CCCA000 at 0x0F8; 0x0000000F at 0x310.
- R9: When `rd_en` and `wr_en` are high in the same cycle, the write is carried out and the read is dropped, so `rvalid` stays low.
- R10: `err` and `unimpl` are single-cycle pulses. They are low in any cycle that does not follow an access of their kind, and `unimpl` is never high together with `err` or `rvalid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, loads the default words |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after the read strobe |
| rvalid | output | 1 | High in the cycle that carries read data |
| err | output | 1 | Pulse after an out-of-range access |
| unimpl | output | 1 | Pulse after a write to a word with no special handling |

## Verification
The bench reads every word after reset against the default list. It then writes three patterns to every in-range word, chosen so that each side effect bit starts in the state that exposes a mistake: the enable bit set with the lock bit clear, the lock bit set with the enable bit clear, and both update strobes set. A design that forces lock without checking the enable bit, or that leaves an update strobe stored, reads back the wrong word. The bench sweeps every out-of-range word index, first with reads and then with writes, and afterwards reads back every in-range word. A decoder that truncates the index would let a write at 0x400 overwrite word 0, and a decoder with an off-by-one boundary would raise `err` at 0x320 or miss it at 0x324. Other checks cover the low address bits being ignored, simultaneous strobes (a design that serves the read raises `rvalid`), the pulse widths, and a second reset in the middle of the run.

// File: rtl/clkctl_pkg.sv
`timescale 1ns/1ps
package clkctl_pkg;

    localparam int WORD_W       = 32;
    localparam int EN_BIT       = 31;
    localparam int LOCK_BIT     = 28;
    localparam int DDR1_UPD_BIT = 30;
    localparam int DRAM_UPD_BIT = 16;
    localparam int IDX_DDR1     = 19;   // byte offset 0x04C
    localparam int IDX_DRAM_CFG = 61;   // byte offset 0x0F4

    typedef enum logic [1:0] {
        K_PLAIN,
        K_PLL,
        K_PLL_DDR1,
        K_DRAM_CFG
    } reg_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_OK,
        ST_READ_OOB,
        ST_WRITE_STORED,
        ST_WRITE_PLAIN,
        ST_WRITE_OOB
    } acc_state_e;

    // Write handling class of a word index.
    function automatic reg_kind_e kind_of(int unsigned idx);
        case (idx)
            0, 2, 4, 6, 8, 10, 11, 12, 13, 14, 16, 18: kind_of = K_PLL;
            IDX_DDR1:                                  kind_of = K_PLL_DDR1;
            IDX_DRAM_CFG:                              kind_of = K_DRAM_CFG;
            default:                                   kind_of = K_PLAIN;
        endcase
    endfunction

    // Power-on content of a word index.
    function automatic logic [WORD_W-1:0] reset_word(int unsigned idx);
        case (idx)
            0, 8:               reset_word = 32'h0000_1000;
            2:                  reset_word = 32'h0003_5514;
            4, 6, 12, 14, 18:   reset_word = 32'h0300_6207;
            10, 11:             reset_word = 32'h0004_1811;
            13:                 reset_word = 32'h0000_1811;
            16:                 reset_word = 32'h0000_0515;
            19:                 reset_word = 32'h0000_1800;
            21:                 reset_word = 32'h0000_1010;
            22:                 reset_word = 32'h0100_0000;
            60:                 reset_word = 32'h0000_0001;
            62:                 reset_word = 32'h0CCC_A000;
            196:                reset_word = 32'h0000_000F;
            default:            reset_word = '0;
        endcase
    endfunction

endpackage

// File: rtl/clkctl_decode.sv
`timescale 1ns/1ps
module clkctl_decode
    import clkctl_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 201,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              in_range,
    output reg_kind_e         kind
);
    localparam int FULL_W = ADDR_W - 2;

    logic [FULL_W-1:0] full_idx;
    logic              unused_byte_lane;

    assign full_idx         = addr[ADDR_W-1:2];
    assign unused_byte_lane = ^addr[1:0];

    // Full-width compare: upper index bits never alias into the array.
    assign in_range = (full_idx < FULL_W'(NUM_WORDS));
    assign idx      = full_idx[IDX_W-1:0];
    assign kind     = kind_of(32'(full_idx));

endmodule

// File: rtl/clkctl_wshape.sv
`timescale 1ns/1ps
module clkctl_wshape
    import clkctl_pkg::*;
(
    input  reg_kind_e          kind,
    input  logic [WORD_W-1:0]  wdata,
    output logic [WORD_W-1:0]  wval,
    output logic               is_plain
);
    always_comb begin
        wval = wdata;
        unique case (kind)
            K_PLL: begin
                if (wdata[EN_BIT]) wval[LOCK_BIT] = 1'b1;
            end
            K_PLL_DDR1: begin
                wval[DDR1_UPD_BIT] = 1'b0;
                if (wdata[EN_BIT]) wval[LOCK_BIT] = 1'b1;
            end
            K_DRAM_CFG: begin
                wval[DRAM_UPD_BIT] = 1'b0;
            end
            default: begin
            end
        endcase
    end

    assign is_plain = (kind == K_PLAIN);

endmodule

// File: rtl/clkctl_store.sv
`timescale 1ns/1ps
module clkctl_store
    import clkctl_pkg::*;
#(
    parameter int NUM_WORDS = 201,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wval,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rword
);
    logic [WORD_W-1:0] words [NUM_WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                words[i] <= reset_word(i);
            end
        end else if (we) begin
            words[widx] <= wval;
        end
    end

    assign rword = words[ridx];

    // An enabled PLL word always reports lock (R2, R4).
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_pll_chk
        if (kind_of(g) == K_PLL || kind_of(g) == K_PLL_DDR1) begin : g_pll
            p_enabled_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
                words[g][EN_BIT] |-> words[g][LOCK_BIT]);
        end
    end

    p_ddr1_upd_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !words[IDX_DDR1][DDR1_UPD_BIT]);

    p_dram_upd_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !words[IDX_DRAM_CFG][DRAM_UPD_BIT]);

endmodule

// File: rtl/clkctl_regbank.sv
`timescale 1ns/1ps
module clkctl_regbank
    import clkctl_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 201
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rvalid,
    output logic              err,
    output logic              unimpl
);
    localparam int IDX_W = $clog2(NUM_WORDS);

    logic [IDX_W-1:0]  idx;
    logic              in_range;
    reg_kind_e         kind;
    logic [WORD_W-1:0] wval;
    logic              is_plain;
    logic [WORD_W-1:0] rword;
    logic [WORD_W-1:0] rdata_q;
    acc_state_e        state_q, state_d;

    clkctl_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_decode (
        .addr     (addr),
        .idx      (idx),
        .in_range (in_range),
        .kind     (kind)
    );

    clkctl_wshape u_wshape (
        .kind     (kind),
        .wdata    (wdata),
        .wval     (wval),
        .is_plain (is_plain)
    );

    clkctl_store #(.NUM_WORDS(NUM_WORDS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && in_range),
        .widx  (idx),
        .wval  (wval),
        .ridx  (idx),
        .rword (rword)
    );

    // Next state: the strobes of this cycle name the response.
    always_comb begin
        if (wr_en) begin
            if (!in_range)     state_d = ST_WRITE_OOB;
            else if (is_plain) state_d = ST_WRITE_PLAIN;
            else               state_d = ST_WRITE_STORED;
        end else if (rd_en) begin
            state_d = in_range ? ST_READ_OK : ST_READ_OOB;
        end else begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= (rd_en && !wr_en && in_range) ? rword : '0;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        rvalid = 1'b0;
        err    = 1'b0;
        unimpl = 1'b0;
        unique case (state_q)
            ST_IDLE:         ;
            ST_READ_OK:      rvalid = 1'b1;
            ST_READ_OOB:     begin rvalid = 1'b1; err = 1'b1; end
            ST_WRITE_STORED: ;
            ST_WRITE_PLAIN:  unimpl = 1'b1;
            ST_WRITE_OOB:    err = 1'b1;
            default:         ;
        endcase
    end

    assign rdata = rdata_q;

    p_read_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> rvalid);

    p_oob_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && err) |-> (rdata == '0));

    p_err_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past((rd_en || wr_en) && !in_range));

    p_write_drops_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !rvalid);

    p_unimpl_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(unimpl && (err || rvalid)));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en) |=> (!err && !unimpl && !rvalid && rdata == '0));

endmodule

// File: tb/clkctl_regbank_test.sv
`timescale 1ns/1ps
module clkctl_regbank_test;

    localparam int NW = 201;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rd_en, wr_en;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        rvalid, err, unimpl;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] model [NW];
    logic [31:0] s_rdata;
    logic        s_rvalid, s_err, s_unimpl;

    always #4 clk = ~clk;

    clkctl_regbank uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .err(err), .unimpl(unimpl)
    );

    function automatic logic [31:0] exp_default(int i);
        case (i)
            0, 8:             return 32'h0000_1000;
            2:                return 32'h0003_5514;
            4, 6, 12, 14, 18: return 32'h0300_6207;
            10, 11:           return 32'h0004_1811;
            13:               return 32'h0000_1811;
            16:               return 32'h0000_0515;
            19:               return 32'h0000_1800;
            21:               return 32'h0000_1010;
            22:               return 32'h0100_0000;
            60:               return 32'h0000_0001;
            62:               return 32'h0CCC_A000;
            196:              return 32'h0000_000F;
            default:          return 32'h0;
        endcase
    endfunction

    function automatic bit is_pll(int i);
        return (i inside {0, 2, 4, 6, 8, 10, 11, 12, 13, 14, 16, 18});
    endfunction

    function automatic logic [31:0] exp_store(int i, logic [31:0] v);
        logic [31:0] r = v;
        if ((is_pll(i) || i == 19) && v[31]) r[28] = 1'b1;
        if (i == 19) r[30] = 1'b0;
        if (i == 61) r[16] = 1'b0;
        return r;
    endfunction

    function automatic string tag_of(int i);
        if (is_pll(i)) return "R2/R3";
        if (i == 19)   return "R4";
        if (i == 61)   return "R5";
        return "R7";
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_read(logic [11:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        s_rdata = rdata; s_rvalid = rvalid; s_err = err; s_unimpl = unimpl;
        rd_en = 1'b0;
    endtask

    task automatic do_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        s_rdata = rdata; s_rvalid = rvalid; s_err = err; s_unimpl = unimpl;
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NW; i++) model[i] = exp_default(i);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] pats [3];
        pats[0] = 32'hCA5B_C3E1;   // enable set, lock clear, both strobes set
        pats[1] = 32'h3FFF_FFFF;   // enable clear, lock set
        pats[2] = 32'h2000_0001;   // enable clear, lock clear
        rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        do_reset();

        // R10: quiet outputs after reset
        @(negedge clk);
        check("R10", "rvalid after reset", 32'(rvalid), 32'h0);
        check("R10", "err after reset", 32'(err), 32'h0);
        check("R1", "rdata after reset", rdata, 32'h0);

        // R8, R1: every default word
        for (int i = 0; i < NW; i++) begin
            do_read(12'(i * 4));
            check("R8", $sformatf("default word %0d", i), s_rdata, exp_default(i));
            check("R1", "rvalid on read", 32'(s_rvalid), 32'h1);
        end

        // R6: out-of-range reads
        for (int i = NW; i < 1024; i++) begin
            do_read(12'(i * 4));
            check("R6", $sformatf("oob read data %0d", i), s_rdata, 32'h0);
            check("R6", "oob read err", {30'h0, s_rvalid, s_err}, 32'h3);
        end

        // R2..R5, R7: write patterns to every in-range word
        for (int p = 0; p < 3; p++) begin
            for (int i = 0; i < NW; i++) begin
                do_write(12'(i * 4), pats[p]);
                model[i] = exp_store(i, pats[p]);
                check("R7", $sformatf("unimpl after write %0d", i), 32'(s_unimpl),
                      32'((tag_of(i) == "R7") ? 1 : 0));
                check("R6", "err on in-range write", 32'(s_err), 32'h0);
                @(negedge clk);
                check("R10", "unimpl pulse width", 32'(unimpl), 32'h0);
                do_read(12'(i * 4));
                check(tag_of(i), $sformatf("stored word %0d", i), s_rdata, model[i]);
            end
        end

        // R6: out-of-range writes change nothing
        for (int i = NW; i < 1024; i++) begin
            do_write(12'(i * 4), 32'hDEAD_BEEF);
            check("R6", $sformatf("oob write err %0d", i), {30'h0, s_err, s_unimpl}, 32'h2);
        end
        for (int i = 0; i < NW; i++) begin
            do_read(12'(i * 4));
            check("R6", $sformatf("word %0d after oob writes", i), s_rdata, model[i]);
        end

        // R1: low address bits ignored
        do_read(12'h017);
        check("R1", "low bits ignored", s_rdata, model[5]);

        // R9: simultaneous strobes
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; addr = 12'h078; wdata = 32'h1234_5678;
        @(negedge clk);
        check("R9", "rvalid with both strobes", 32'(rvalid), 32'h0);
        rd_en = 1'b0; wr_en = 1'b0;
        do_read(12'h078);
        check("R9", "write performed", s_rdata, 32'h1234_5678);

        // R8: second reset restores defaults
        do_reset();
        do_read(12'h000);
        check("R8", "word 0 after second reset", s_rdata, 32'h0000_1000);
        do_read(12'h078);
        check("R8", "plain word after second reset", s_rdata, 32'h0);
        do_read(12'h310);
        check("R8", "word 0x310 after second reset", s_rdata, 32'h0000_000F);

        summary();
    end

endmodule